// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer of a voltage-mode buck controller. A counter stands in for the soft-start capacitor voltage. The counter climbs at a fixed rate once both supply power-good flags and the enable input are high. The block turns the counter into a reference code for the error amplifier, asks for the gate drivers once the reference starts to move, and flags when the soft-start has finished.

It also qualifies the raw overcurrent comparator against the high-side on-time. The first part of every high-side pulse is blanked out, and a trip also needs the comparator to stay high for a minimum time. A qualified trip turns the drivers off and drops the done flag. The counter then drains linearly at the charge rate, and a new soft-start begins from zero. A trip taken during the ramp lets the counter finish climbing to its top before the drain starts. A fault that persists therefore gives a hiccup cycle with a fixed period.

Counter codes map to volts: with the default parameters one volt is 128 codes, the counter steps by 4 per cycle, and its top level of 512 stands for 4 V.

Top module: `sst_softstart_seq`

## Requirements
- R1: While reset is asserted, and directly after it, ref_code is 0 and drv_en, ss_done and dischg are all 0.
- R2: The inputs pg_vcc, pg_pvcc, en, use_ext, oc_raw and hs_on each pass through a two-flop synchronizer. Counting starts when all three of pg_vcc, pg_pvcc and en are high. The counter is 0 in the third cycle after those inputs rise, then gains STEP (4) per cycle and saturates at LVL_TOP (512).
- R3: When any of pg_vcc, pg_pvcc or en goes low, all outputs are 0 from the third cycle after the change. The counter is cleared, so the next soft-start begins from 0.
- R4: With use_ext low, ref_code is 0 while the counter c is below LVL_1V (128). It equals floor((c-128)*REF_INT/(LVL_3V-LVL_1V)), with REF_INT = 76 and LVL_3V = 384, while 128 <= c < 384. It equals 76 from c = 384 upward.
- R5: With use_ext high, ref_code is 0 while c < 128, and min(c-128, ext_ref) from c = 128 on.
- R6: During a fault-free soft-start, drv_en is 1 exactly while c >= 128. ss_done is 1 exactly while c = 512.
- R7: An overcurrent sample counts only after hs_on has been high for BLANK_CYC (6) earlier cycles. A high-side pulse shorter than BLANK_CYC+FILT_CYC (12) cycles never trips, even with oc_raw high throughout.
- R8: A trip needs FILT_CYC (6) qualified samples in a row. Shorter oc_raw pulses are ignored, and so is any overcurrent while drv_en is 0.
- R9: A trip taken at the top level enters discharge at once. ss_done and drv_en fall and dischg rises in the same cycle, 15 cycles after oc_raw and hs_on rise together. dischg stays high for LVL_TOP/STEP (128) cycles, and ss_done returns 128 cycles after dischg falls.
- R10: A trip taken during the ramp turns drv_en off 7 cycles after it rose and keeps ss_done low. dischg rises only when the counter reaches the top, 128 cycles after charging began.
- R11: Under a persistent fault the block alternates 128 cycles of discharge and 128 cycles of recharge without asserting ss_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_vcc | input | 1 | Bias supply power-good |
| pg_pvcc | input | 1 | Driver supply power-good |
| en | input | 1 | Converter enable |
| use_ext | input | 1 | Selects the external reference path |
| ext_ref | input | CW | External reference code, static while in use |
| oc_raw | input | 1 | Raw overcurrent comparator output |
| hs_on | input | 1 | High-side switch on indication |
| ref_code | output | CW | Scaled reference code for the error amplifier |
| drv_en | output | 1 | Gate-driver enable request |
| ss_done | output | 1 | Soft-start finished |
| dischg | output | 1 | Soft-start counter discharging after a fault |

## Verification
The reference mapping is swept across the whole ramp three times: with the internal reference, with an external value of 100 that clips early in the ramp, and with an external value of 300 that clips near its end. These sweeps separate the two reference paths and their clipping points, and they pin down when the drivers turn on and when the done flag rises. The overcurrent path is driven with high-side pulses one cycle shorter than the blanking plus filter time, with comparator pulses one cycle shorter than the filter, and with a full-length event. This shows that blanking and filtering each hold back a trip on their own. Faults are injected both at the top level and during the ramp, and a fault is held on to observe the hiccup loop. Separately, each supply-good input and the enable are dropped to check that the block shuts down and restarts from zero.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_CHARGE,
    ST_RAMP,
    ST_DONE,
    ST_FLT_CHG,
    ST_FLT_DIS
  } sst_state_e;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/sst_ocp_qual.sv
module sst_ocp_qual #(
  parameter int BLANK_CYC = 6,
  parameter int FILT_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hs_on,
  input  logic oc,
  output logic trip
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [BW-1:0] blank_q, blank_d;
  logic [FW-1:0] filt_q, filt_d;
  logic          past_blank, qual;

  always_comb begin
    past_blank = (blank_q == BW'(BLANK_CYC));
    qual       = hs_on && past_blank && oc && arm;
    if (!hs_on)          blank_d = '0;
    else if (past_blank) blank_d = blank_q;
    else                 blank_d = blank_q + 1'b1;
    if (!qual)                        filt_d = '0;
    else if (filt_q == FW'(FILT_CYC)) filt_d = filt_q;
    else                              filt_d = filt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      filt_q  <= '0;
    end else begin
      blank_q <= blank_d;
      filt_q  <= filt_d;
    end
  end

  assign trip = arm && (filt_q == FW'(FILT_CYC));
endmodule

// File: rtl/sst_ref_map.sv
module sst_ref_map #(
  parameter int CW      = 10,
  parameter int LVL_1V  = 128,
  parameter int LVL_3V  = 384,
  parameter int REF_INT = 76
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] ext_ref,
  input  logic          use_ext,
  output logic [CW-1:0] ref_code
);
  localparam int SPAN = LVL_3V - LVL_1V;
  localparam int PW   = 2 * CW;

  logic [CW-1:0] diff;
  logic [PW-1:0] prod;

  always_comb begin
    diff = cnt - CW'(LVL_1V);
    prod = {{CW{1'b0}}, diff} * PW'(REF_INT);
    if (cnt < CW'(LVL_1V))      ref_code = '0;
    else if (use_ext)           ref_code = (diff < ext_ref) ? diff : ext_ref;
    else if (cnt >= CW'(LVL_3V)) ref_code = CW'(REF_INT);
    else                        ref_code = CW'(prod / PW'(SPAN));
  end
endmodule

// File: rtl/sst_softstart_seq.sv
module sst_softstart_seq
  import sst_pkg::*;
#(
  parameter int CW        = 10,
  parameter int LVL_1V    = 128,
  parameter int LVL_3V    = 384,
  parameter int LVL_TOP   = 512,
  parameter int STEP      = 4,
  parameter int REF_INT   = 76,
  parameter int BLANK_CYC = 6,
  parameter int FILT_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_vcc,
  input  logic          pg_pvcc,
  input  logic          en,
  input  logic          use_ext,
  input  logic [CW-1:0] ext_ref,
  input  logic          oc_raw,
  input  logic          hs_on,
  output logic [CW-1:0] ref_code,
  output logic          drv_en,
  output logic          ss_done,
  output logic          dischg
);
  localparam int NSYNC = 6;

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic [NSYNC-1:0] sync_q;
  logic pg_vcc_s, pg_pvcc_s, en_s, use_ext_s, oc_s, hs_s, go_s;

  sst_sync #(.N(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({pg_vcc, pg_pvcc, en, use_ext, oc_raw, hs_on}),
    .q     (sync_q)
  );
  assign {pg_vcc_s, pg_pvcc_s, en_s, use_ext_s, oc_s, hs_s} = sync_q;
  assign go_s = pg_vcc_s && pg_pvcc_s && en_s;

  sst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, cnt_dec;
  logic [CW:0]   cnt_sum;
  logic          cnt_ce, trip;

  sst_ocp_qual #(.BLANK_CYC(BLANK_CYC), .FILT_CYC(FILT_CYC)) u_ocp (
    .clk   (clk),
    .rst_n (rst_i_n),
    .arm   (drv_en),
    .hs_on (hs_s),
    .oc    (oc_s),
    .trip  (trip)
  );

  always_comb begin
    cnt_sum = {1'b0, cnt_q} + (CW+1)'(STEP);
    cnt_inc = (cnt_sum >= (CW+1)'(LVL_TOP)) ? CW'(LVL_TOP) : cnt_sum[CW-1:0];
    cnt_dec = (cnt_q <= CW'(STEP)) ? '0 : cnt_q - CW'(STEP);
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!go_s) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_CHARGE;
        ST_CHARGE: begin
          cnt_d = cnt_inc;
          if (cnt_inc >= CW'(LVL_1V)) state_d = ST_RAMP;
        end
        ST_RAMP: begin
          cnt_d = cnt_inc;
          if (trip) state_d = (cnt_inc == CW'(LVL_TOP)) ? ST_FLT_DIS : ST_FLT_CHG;
          else if (cnt_inc == CW'(LVL_TOP)) state_d = ST_DONE;
        end
        ST_DONE: if (trip) state_d = ST_FLT_DIS;
        ST_FLT_CHG: begin
          cnt_d = cnt_inc;
          if (cnt_inc == CW'(LVL_TOP)) state_d = ST_FLT_DIS;
        end
        ST_FLT_DIS: begin
          cnt_d = cnt_dec;
          if (cnt_dec == '0) state_d = ST_CHARGE;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  assign cnt_ce = go_s || (cnt_q != '0);

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  sst_ref_map #(.CW(CW), .LVL_1V(LVL_1V), .LVL_3V(LVL_3V), .REF_INT(REF_INT)) u_ref (
    .cnt      (cnt_q),
    .ext_ref  (ext_ref),
    .use_ext  (use_ext_s),
    .ref_code (ref_code)
  );

  assign drv_en  = (state_q == ST_RAMP) || (state_q == ST_DONE);
  assign ss_done = (state_q == ST_DONE);
  assign dischg  = (state_q == ST_FLT_DIS);
endmodule

// File: rtl/sst_softstart_seq_chk.sv
module sst_softstart_seq_chk #(
  parameter int CW      = 10,
  parameter int LVL_TOP = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [CW-1:0] cnt,
  input logic          drv_en,
  input logic          ss_done,
  input logic          dischg
);
  assert_done_drv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> drv_en);

  assert_done_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (cnt == CW'(LVL_TOP)));

  assert_dis_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dischg |-> (!drv_en && !ss_done));

  assert_off_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!drv_en && !ss_done && !dischg && cnt == '0));

  assert_dis_falls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dischg && $past(dischg)) |-> (cnt < $past(cnt)));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LVL_TOP));
endmodule

bind sst_softstart_seq sst_softstart_seq_chk #(.CW(CW), .LVL_TOP(LVL_TOP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go_s),
  .cnt     (cnt_q),
  .drv_en  (drv_en),
  .ss_done (ss_done),
  .dischg  (dischg)
);

// File: tb/sst_softstart_seq_bench.sv
module sst_softstart_seq_bench;
  localparam int CW = 10;
  localparam int V1 = 128, V3 = 384, TOP = 512, STP = 4, RI = 76;

  logic clk = 1'b0;
  logic rst_n, pg_vcc, pg_pvcc, en, use_ext, oc_raw, hs_on;
  logic [CW-1:0] ext_ref, ref_code;
  logic drv_en, ss_done, dischg;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  sst_softstart_seq u_sst_softstart_seq (
    .clk(clk), .rst_n(rst_n), .pg_vcc(pg_vcc), .pg_pvcc(pg_pvcc), .en(en),
    .use_ext(use_ext), .ext_ref(ext_ref), .oc_raw(oc_raw), .hs_on(hs_on),
    .ref_code(ref_code), .drv_en(drv_en), .ss_done(ss_done), .dischg(dischg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ref(input int c, input bit ext, input int ev);
    if (c < V1) return 0;
    if (ext) return ((c - V1) < ev) ? (c - V1) : ev;
    if (c >= V3) return RI;
    return ((c - V1) * RI) / (V3 - V1);
  endfunction

  // full ramp from zero; inputs change on falling edges, outputs sampled there
  task automatic sweep(input bit ext, input int ev, input string req);
    @(negedge clk) en = 1'b0;
    repeat (6) @(negedge clk);
    use_ext = ext;
    ext_ref = CW'(ev);
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k <= 140; k++) begin
      int c;
      c = (k * STP > TOP) ? TOP : k * STP;
      chk(req, "ref_code", int'(ref_code), exp_ref(c, ext, ev));
      chk("R6", "drv_en", int'(drv_en), int'(c >= V1));
      chk("R6", "ss_done", int'(ss_done), int'(c == TOP));
      @(negedge clk);
    end
  endtask

  task automatic check_off(input string what);
    repeat (2) @(negedge clk);
    chk("R3", {what, " ss_done still high at second cycle"}, int'(ss_done), 1);
    @(negedge clk);
    chk("R3", {what, " drv_en"}, int'(drv_en), 0);
    chk("R3", {what, " ss_done"}, int'(ss_done), 0);
    chk("R3", {what, " dischg"}, int'(dischg), 0);
    chk("R3", {what, " ref_code"}, int'(ref_code), 0);
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; pg_vcc = 1'b0; pg_pvcc = 1'b0; en = 1'b0; use_ext = 1'b0;
    oc_raw = 1'b0; hs_on = 1'b0; ext_ref = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "ref_code", int'(ref_code), 0);
    chk("R1", "drv_en", int'(drv_en), 0);
    chk("R1", "ss_done", int'(ss_done), 0);
    chk("R1", "dischg", int'(dischg), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ss_done after release", int'(ss_done), 0);
    pg_vcc = 1'b1; pg_pvcc = 1'b1;

    // R2 R4 internal reference ramp
    sweep(1'b0, 0, "R4");
    @(negedge clk) en = 1'b0;
    check_off("en low");

    // R5 external reference clipped early
    sweep(1'b1, 100, "R5");
    @(negedge clk) pg_pvcc = 1'b0;
    check_off("pg_pvcc low");
    pg_pvcc = 1'b1;

    // R5 external reference clipped late; R2 restart from zero
    sweep(1'b1, 300, "R5");
    @(negedge clk) pg_vcc = 1'b0;
    check_off("pg_vcc low");
    pg_vcc = 1'b1;
    sweep(1'b1, 300, "R2");

    // R7 high-side pulses one cycle short of blank+filter
    @(negedge clk) oc_raw = 1'b1;
    for (int p = 0; p < 3; p++) begin
      hs_on = 1'b1;
      repeat (11) @(negedge clk);
      hs_on = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R7", "ss_done after short pulses", int'(ss_done), 1);
    chk("R7", "dischg after short pulses", int'(dischg), 0);

    // R8 comparator pulses one cycle short of the filter
    oc_raw = 1'b0; hs_on = 1'b1;
    repeat (10) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      oc_raw = 1'b1;
      repeat (5) @(negedge clk);
      oc_raw = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R8", "ss_done after short oc pulses", int'(ss_done), 1);
    chk("R8", "dischg after short oc pulses", int'(dischg), 0);
    hs_on = 1'b0;
    repeat (4) @(negedge clk);

    // R9 fault at top level
    hs_on = 1'b1; oc_raw = 1'b1;
    repeat (14) @(negedge clk);
    chk("R9", "ss_done one cycle before trip", int'(ss_done), 1);
    @(negedge clk);
    chk("R9", "ss_done at trip", int'(ss_done), 0);
    chk("R9", "drv_en at trip", int'(drv_en), 0);
    chk("R9", "dischg at trip", int'(dischg), 1);
    hs_on = 1'b0; oc_raw = 1'b0;
    n = 1;
    for (int g = 0; g < 400; g++) begin
      @(negedge clk);
      if (!dischg) break;
      n++;
    end
    chk("R9", "discharge length", n, TOP / STP);
    repeat (127) @(negedge clk);
    chk("R9", "ss_done before restart top", int'(ss_done), 0);
    @(negedge clk);
    chk("R9", "ss_done after restart", int'(ss_done), 1);

    // R10 fault during ramp, oc held while drivers off (R8)
    @(negedge clk) en = 1'b0;
    use_ext = 1'b0;
    hs_on = 1'b1; oc_raw = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k <= 128; k++) begin
      chk("R10", "drv_en", int'(drv_en), int'(k >= 32 && k <= 38));
      chk("R10", "ss_done", int'(ss_done), 0);
      chk("R10", "dischg", int'(dischg), int'(k == 128));
      if (k == 32) chk("R8", "drivers on despite earlier oc", int'(drv_en), 1);
      if (k < 128) @(negedge clk);
    end

    // R11 hiccup loop with fault held
    for (int cyc = 0; cyc < 2; cyc++) begin
      int hi, lo, dn;
      hi = 1; lo = 0; dn = 0;
      for (int g = 0; g < 400; g++) begin
        @(negedge clk);
        if (ss_done) dn++;
        if (!dischg) break;
        hi++;
      end
      lo = 1;
      for (int g = 0; g < 400; g++) begin
        @(negedge clk);
        if (ss_done) dn++;
        if (dischg) break;
        lo++;
      end
      chk("R11", "hiccup discharge cycles", hi, 128);
      chk("R11", "hiccup recharge cycles", lo, 128);
      chk("R11", "ss_done during hiccup", dn, 0);
    end
    en = 1'b0; hs_on = 1'b0; oc_raw = 1'b0;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule